// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers interrupt lines from up to 32 peripherals into one status register and combines them with a mask register. It drives one request line to the processor. Each peripheral line is either level-sensed or rising-edge-sensed, and a parameter picks the sensing per line. Once a status bit is set it stays set until software clears it. Software clears a bit by writing a one to it in the status register.

Both registers sit on a special-purpose register bus. A register is selected by a 16-bit number made from a 5-bit group and an 11-bit index: number = (group << 11) + index. The controller answers in group 9. Index 0 is the mask and index 2 is the status. The request output is registered. It is high whenever some bit is set in both status and mask, so rewriting the mask alone can raise or drop it.

Top module: `masked_irq_ctrl`

## Requirements
- R1: While reset is asserted, mask and status are zero and `irq_o` is low. They stay so until the first write or source activity after reset.
- R2: Only register number 0x4800 (mask: group 9, index 0) and 0x4802 (status: group 9, index 2) respond. A write to any other number changes neither register. A read of any other number returns zero.
- R3: A write to the status register clears each status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A source configured as level-sensed sets its status bit at every clock edge at which its input is high.
- R5: A source configured as edge-sensed sets its status bit only at a clock edge where its input is high and was low at the previous edge. By default sources 16..31 are edge-sensed and 0..15 are level-sensed. A held-high edge source does not set its bit again after software clears it.
- R6: When a source sets a status bit and a status write clears the same bit at the same edge, the bit ends up set.
- R7: `irq_o` equals the OR of (status AND mask) as it stood after the previous clock edge. It therefore follows any register change one clock later.
- R8: A write to the mask register replaces the whole mask. The request is re-evaluated from the new mask, which can raise or lower it with no change in status.
- R9: A read of the mask or status register returns its current contents on `reg_rdata` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Peripheral interrupt lines, one per status bit |
| reg_addr | input | 16 | Register number, group in bits 15:11, index in bits 10:0 |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The properties take the peripheral lines as synchronous to `clk` and held stable across each edge. They also take at most one register access per cycle, given by the address and write strobe of that cycle. The bench drives every input only on the falling edge, so each value is settled well before the rising edge that samples it. The random phase draws addresses from the two live registers and two unmapped numbers. It keeps the source lines sparse so that set, clear and mask changes all occur in both orders and in the same cycle.

// File: rtl/masked_irq_ctrl.sv
module masked_irq_ctrl #(
  parameter int NSRC     = 32,
  parameter int GRP_W    = 5,
  parameter int IDX_W    = 11,
  parameter int GROUP    = 9,
  parameter int MASK_IDX = 0,
  parameter int STAT_IDX = 2,
  parameter logic [NSRC-1:0] EDGE_SRC = 32'hFFFF_0000,
  localparam int AW = GRP_W + IDX_W,
  localparam logic [AW-1:0] MASK_ADDR = AW'((GROUP << IDX_W) + MASK_IDX),
  localparam logic [AW-1:0] STAT_ADDR = AW'((GROUP << IDX_W) + STAT_IDX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_o
);

  logic [NSRC-1:0] mask_q, stat_q, set_v, clr_v;
  logic            hit_mask, hit_stat;

  assign hit_mask = reg_addr == MASK_ADDR;
  assign hit_stat = reg_addr == STAT_ADDR;
  assign clr_v    = (reg_we && hit_stat) ? reg_wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (EDGE_SRC[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[i];
      assign set_v[i] = src_i[i] & ~prev_q;
    end else begin : g_lvl
      assign set_v[i] = src_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (reg_we && hit_mask) mask_q <= reg_wdata;
      stat_q <= (stat_q & ~clr_v) | set_v;
      irq_o  <= |(stat_q & mask_q);
    end
  end

  assign reg_rdata = hit_mask ? mask_q : hit_stat ? stat_q : '0;

endmodule

module masked_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 16,
  parameter logic [NSRC-1:0] EDGE_SRC  = '0,
  parameter logic [AW-1:0]   MASK_ADDR = '0,
  parameter logic [AW-1:0]   STAT_ADDR = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_we,
  input logic [NSRC-1:0] reg_wdata,
  input logic            irq_o,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] stat_q
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && stat_q == '0 && !irq_o));

  a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == |($past(stat_q & mask_q)));

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == STAT_ADDR) |=> (stat_q & $past(reg_wdata) & ~$past(src_i)) == '0);

  a_r4_new_bit_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(src_i)) == '0);

  a_r6_level_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (~EDGE_SRC & $past(src_i) & ~stat_q) == '0);

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == MASK_ADDR) |=> $stable(mask_q));

  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == MASK_ADDR) |=> mask_q == $past(reg_wdata));

endmodule

bind masked_irq_ctrl masked_irq_ctrl_chk #(
  .NSRC(NSRC), .AW(AW), .EDGE_SRC(EDGE_SRC),
  .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/masked_irq_ctrl_test.sv
`timescale 1ns/1ps
module masked_irq_ctrl_test;
  localparam logic [31:0] EDGE = 32'hFFFF_0000;
  localparam logic [15:0] A_MASK = 16'h4800;
  localparam logic [15:0] A_STAT = 16'h4802;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [15:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  always #4 clk = ~clk;

  masked_irq_ctrl #(.EDGE_SRC(EDGE)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] m_mask = '0, m_stat = '0, m_prev = '0;
  logic        m_irq = 1'b0;

  function automatic logic [31:0] exp_rd(input logic [15:0] a);
    if (a == A_MASK) return m_mask;
    if (a == A_STAT) return m_stat;
    return '0;
  endfunction

  task automatic compare(input string req);
    n_chk++;
    if (reg_rdata !== exp_rd(reg_addr)) begin
      n_bad++;
      $display("FAIL %s rdata addr=%h got %h exp %h", req, reg_addr, reg_rdata, exp_rd(reg_addr));
    end
    n_chk++;
    if (irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq got %b exp %b", req, irq_o, m_irq);
    end
  endtask

  task automatic model_edge();
    logic [31:0] clr, set;
    if (!rst_n) begin
      m_mask = '0; m_stat = '0; m_prev = '0; m_irq = 1'b0;
      return;
    end
    m_irq = (m_stat & m_mask) != 0;
    clr = (reg_we && reg_addr == A_STAT) ? reg_wdata : '0;
    for (int i = 0; i < 32; i++)
      set[i] = EDGE[i] ? (src_i[i] && !m_prev[i]) : src_i[i];
    m_stat = (m_stat & ~clr) | set;
    if (reg_we && reg_addr == A_MASK) m_mask = reg_wdata;
    m_prev = src_i;
  endtask

  task automatic cyc(input logic [31:0] s, input logic [15:0] a, input bit we,
                     input logic [31:0] wd, input string req);
    src_i = s; reg_addr = a; reg_we = we; reg_wdata = wd;
    #1;
    compare(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with stimulus that must have no effect
    for (int k = 0; k < 3; k++) cyc(32'hFFFF_FFFF, A_MASK, 1, 32'hFFFF_FFFF, "R1");
    cyc('0, A_STAT, 0, '0, "R1");
    rst_n = 1'b1;
    cyc('0, A_MASK, 0, '0, "R1");
    cyc('0, A_STAT, 0, '0, "R1");
    // R8/R9: mask load and readback
    cyc('0, A_MASK, 1, 32'h0001_00F1, "R8");
    cyc('0, A_MASK, 0, '0, "R9");
    // R4/R7: level source sets status, request follows one clock later
    cyc(32'h1, A_STAT, 0, '0, "R4");
    cyc('0, A_STAT, 0, '0, "R4");
    cyc('0, A_STAT, 0, '0, "R7");
    // R3: write-one-to-clear
    cyc('0, A_STAT, 1, 32'h1, "R3");
    cyc('0, A_STAT, 0, '0, "R3");
    cyc('0, A_STAT, 0, '0, "R7");
    cyc(32'h3, A_STAT, 0, '0, "R4");
    cyc('0, A_STAT, 1, 32'h2, "R3");
    cyc('0, A_STAT, 0, '0, "R3");
    // R6: set and clear in the same cycle
    cyc(32'h1, A_STAT, 1, 32'h1, "R6");
    cyc('0, A_STAT, 0, '0, "R6");
    cyc('0, A_STAT, 1, 32'hFFFF_FFFF, "R3");
    cyc('0, A_STAT, 0, '0, "R3");
    // R5: edge source held high sets once
    cyc(32'h0001_0000, A_STAT, 0, '0, "R5");
    cyc(32'h0001_0000, A_STAT, 0, '0, "R5");
    cyc(32'h0001_0000, A_STAT, 1, 32'h0001_0000, "R5");
    cyc(32'h0001_0000, A_STAT, 0, '0, "R5");
    cyc(32'h0001_0000, A_STAT, 0, '0, "R5");
    cyc('0, A_STAT, 0, '0, "R5");
    cyc(32'h0001_0000, A_STAT, 0, '0, "R5");
    cyc('0, A_STAT, 0, '0, "R5");
    // R8: mask alone raises and drops the request
    cyc(32'h0000_0100, A_STAT, 0, '0, "R8");
    cyc('0, A_MASK, 1, '0, "R8");
    cyc('0, A_MASK, 0, '0, "R8");
    cyc('0, A_MASK, 1, 32'h0000_0100, "R8");
    cyc('0, A_MASK, 0, '0, "R8");
    cyc('0, A_STAT, 0, '0, "R8");
    cyc('0, A_MASK, 1, 32'h0000_0001, "R8");
    cyc('0, A_MASK, 0, '0, "R8");
    cyc('0, A_STAT, 0, '0, "R8");
    // R2: unmapped numbers neither written nor read
    cyc('0, 16'h4801, 1, 32'hFFFF_FFFF, "R2");
    cyc('0, 16'h4000, 1, 32'hFFFF_FFFF, "R2");
    cyc('0, 16'h0802, 1, 32'hFFFF_FFFF, "R2");
    cyc('0, 16'h5000, 1, 32'hFFFF_FFFF, "R2");
    cyc('0, A_MASK, 0, '0, "R2");
    cyc('0, A_STAT, 0, '0, "R2");
    // R7: random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      logic [31:0] s;
      case ($urandom_range(3))
        0: a = A_MASK;
        1: a = A_STAT;
        2: a = 16'h4801;
        default: a = 16'h4000;
      endcase
      s = $urandom() & $urandom() & $urandom();
      cyc(s, a, $urandom_range(3) == 0, $urandom(), "R7");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule